// File: doc/BRIEF.md
# Bidirectional Strobed Bus Port

This block is one 8-bit peripheral port whose single external bus carries data in both directions. Bytes from the CPU go into an output latch. The latch drives the pads only while the peripheral holds its acknowledge low; at every other time the pads are released. Bytes from the peripheral are captured into an input latch while the peripheral holds its strobe low. Two handshake flags report the state of the port. The output-full flag is an active-low pin. The input-full flag is an active-high pin.

The CPU side is stream-shaped. The transmit side is a valid/ready channel. `tx_ready` is high only while the output latch is empty. A byte offered while the latch is full is back-pressured: it stays on `tx_data` until the peripheral acknowledges the previous byte. The receive side is a valid/ready channel too. `rx_valid` is the input-full flag. A byte is consumed at the clock edge where `rx_valid` and `rx_ready` are both high, and the CPU may leave `rx_ready` low for as long as it likes. A new strobe overwrites a byte that has not been read.

One interrupt line combines an input term and an output term, and each term has its own enable bit. The CPU sets and clears the enables with indexed bit commands. A status byte reports the flags, the enables and the interrupt. The peripheral strobe, the acknowledge and the bus pass through a synchronizer of `SYNC_STAGES` flops before the logic uses them. The exception is the pad driver enable, which follows the acknowledge pin directly.

Top module: `sbp_port`

## Requirements
- R1: While reset is held and after it is released, the port shows: `tx_ready`=1, `obf_n`=1, `ibf`=0, `rx_valid`=0, `intr`=0, `status`=8'h00, and `pad_oe`=0 while `ack_n` is high.
- R2: `pad_oe` is high exactly while the `ack_n` pin is low, with no clock delay. `pad_out` always carries the output latch.
- R3: When `stb_n` is low, the synchronized `pad_in` value is loaded into the input latch and `ibf`/`rx_valid` are set, within SYNC_STAGES+1 clock edges. A later strobe replaces a byte that has not been read.
- R4: A receive transfer (`rx_valid` and `rx_ready` high at a clock edge) clears `ibf`/`rx_valid` at that edge, unless the synchronized strobe is low in the same cycle.
- R5: A transmit transfer (`tx_valid` and `tx_ready` high at an edge) loads `tx_data` into the output latch and drives `obf_n` low and `tx_ready` low after that edge. A low synchronized acknowledge returns `obf_n` to 1 and `tx_ready` to 1.
- R6: While the output latch is full, `tx_ready` stays low, an offered byte is not taken, and the latched byte is unchanged.
- R7: A bit command (`bsr_valid` high) with index 6 writes `bsr_value` into the output interrupt enable, and with index 4 into the input interrupt enable. Any other index has no effect.
- R8: The input interrupt term is input-full AND input enable AND synchronized strobe high AND `rx_ready` low. `intr` shows the OR of both terms one clock after they hold.
- R9: The output interrupt term is output latch empty AND output enable AND synchronized acknowledge high AND `tx_valid` low.
- R10: A `cfg_clear` pulse clears both enables, both buffer flags and `intr` at the next edge. It takes priority over every other input in that cycle.
- R11: `status` bit 7 = output latch full (1 when full), bit 6 = output enable, bit 5 = input full, bit 4 = input enable, bit 3 = `intr`, bits 2..0 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_clear | input | 1 | Mode-change pulse; clears enables and flags |
| tx_valid | input | 1 | CPU offers a byte for the peripheral |
| tx_ready | output | 1 | Output latch empty; byte accepted |
| tx_data | input | DATA_W | Byte from the CPU |
| rx_valid | output | 1 | Input latch holds an unread byte |
| rx_ready | input | 1 | CPU reads the input latch |
| rx_data | output | DATA_W | Input latch contents |
| bsr_valid | input | 1 | Bit command strobe |
| bsr_index | input | 3 | Bit command index |
| bsr_value | input | 1 | Value written by the bit command |
| stb_n | input | 1 | Peripheral strobe, active low |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| obf_n | output | 1 | Output latch full, active low |
| ibf | output | 1 | Input latch full |
| intr | output | 1 | Interrupt request |
| pad_in | input | DATA_W | Bus value seen at the pads |
| pad_out | output | DATA_W | Value driven onto the pads |
| pad_oe | output | 1 | Pad driver enable |
| status | output | 8 | Status byte |

## Verification
Most wrong internal state in this block reaches the ports within a cycle or two. A stuck or missing full flag shows at once on `tx_ready`, `obf_n`, `rx_valid` and the status byte. It then shows again as `intr` asserting or failing to assert one edge later. A corrupted latch stays hidden until the next acknowledge pulse or receive transfer, so each pushed byte is compared against a scoreboard at exactly that moment. Back-pressure faults show as the wrong byte during an acknowledge. A clear that is not complete, or an enable decoded from the wrong index, shows in the status byte two edges after the command.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  localparam int CTL_W = 8;
  localparam int IDX_W = 3;

  // bit-command indices decoded by the enable logic
  localparam logic [IDX_W-1:0] IDX_OUT_EN = 3'd6;
  localparam logic [IDX_W-1:0] IDX_IN_EN  = 3'd4;

  // status byte positions
  localparam int ST_FULL   = 7;
  localparam int ST_OUT_EN = 6;
  localparam int ST_IBF    = 5;
  localparam int ST_IN_EN  = 4;
  localparam int ST_IRQ    = 3;

  typedef struct packed {
    logic out_en;
    logic in_en;
  } irq_en_t;
endpackage

// File: rtl/sbp_sync.sv
module sbp_sync #(
  parameter int            W      = 1,
  parameter int            STAGES = 2,
  parameter logic [W-1:0]  INIT   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
        end else begin
          stg[0] <= d;
          for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
      end
      assign q = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/sbp_rx.sv
module sbp_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              stb_s,
  input  logic [DATA_W-1:0] bus_s,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (clr) begin
      full <= 1'b0;
    end else if (!stb_s) begin
      // capture continues while the strobe is held low
      full <= 1'b1;
      data <= bus_s;
    end else if (take && full) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/sbp_tx.sv
module sbp_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ack_s,
  output logic              ready,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  assign ready = !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (clr) begin
      full <= 1'b0;
    end else if (wr_valid && !full) begin
      full <= 1'b1;
      data <= wr_data;
    end else if (!ack_s) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/sbp_irq.sv
module sbp_irq
  import sbp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cmd_valid,
  input  logic [IDX_W-1:0] cmd_index,
  input  logic             cmd_value,
  input  logic             in_full,
  input  logic             out_full,
  input  logic             stb_idle,
  input  logic             ack_idle,
  input  logic             rd_active,
  input  logic             wr_active,
  output irq_en_t          en,
  output logic             irq
);
  irq_en_t en_q;
  logic    in_term, out_term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (clr) begin
      en_q <= '0;
    end else if (cmd_valid) begin
      case (cmd_index)
        IDX_OUT_EN: en_q.out_en <= cmd_value;
        IDX_IN_EN:  en_q.in_en  <= cmd_value;
        default: ;
      endcase
    end
  end

  assign in_term  = in_full && en_q.in_en && stb_idle && !rd_active;
  assign out_term = !out_full && en_q.out_en && ack_idle && !wr_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   irq <= 1'b0;
    else if (clr) irq <= 1'b0;
    else          irq <= in_term || out_term;
  end

  assign en = en_q;
endmodule

// File: rtl/sbp_port.sv
module sbp_port
  import sbp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_clear,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  input  logic              bsr_valid,
  input  logic [IDX_W-1:0]  bsr_index,
  input  logic              bsr_value,
  input  logic              stb_n,
  input  logic              ack_n,
  output logic              obf_n,
  output logic              ibf,
  output logic              intr,
  input  logic [DATA_W-1:0] pad_in,
  output logic [DATA_W-1:0] pad_out,
  output logic              pad_oe,
  output logic [CTL_W-1:0]  status
);
  logic [1:0]        hs_s;
  logic              stb_s, ack_s;
  logic [DATA_W-1:0] bus_s;
  logic              in_full, out_full;
  irq_en_t           en;
  logic              ie_in, ie_out;

  sbp_sync #(.W(2), .STAGES(SYNC_STAGES), .INIT(2'b11)) u_hs_sync (
    .clk(clk), .rst_n(rst_n), .d({stb_n, ack_n}), .q(hs_s)
  );
  assign stb_s = hs_s[1];
  assign ack_s = hs_s[0];

  sbp_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .INIT('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(bus_s)
  );

  sbp_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(cfg_clear), .stb_s(stb_s), .bus_s(bus_s),
    .take(rx_ready), .full(in_full), .data(rx_data)
  );

  sbp_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(cfg_clear), .wr_valid(tx_valid),
    .wr_data(tx_data), .ack_s(ack_s), .ready(tx_ready), .full(out_full),
    .data(pad_out)
  );

  sbp_irq u_irq (
    .clk(clk), .rst_n(rst_n), .clr(cfg_clear), .cmd_valid(bsr_valid),
    .cmd_index(bsr_index), .cmd_value(bsr_value), .in_full(in_full),
    .out_full(out_full), .stb_idle(stb_s), .ack_idle(ack_s),
    .rd_active(rx_ready), .wr_active(tx_valid), .en(en), .irq(intr)
  );

  assign ie_in    = en.in_en;
  assign ie_out   = en.out_en;
  assign rx_valid = in_full;
  assign ibf      = in_full;
  assign obf_n    = !out_full;
  // driver follows the raw acknowledge pin so the bus turns around at once
  assign pad_oe   = !ack_n;

  always_comb begin
    status            = '0;
    status[ST_FULL]   = out_full;
    status[ST_OUT_EN] = ie_out;
    status[ST_IBF]    = in_full;
    status[ST_IN_EN]  = ie_in;
    status[ST_IRQ]    = intr;
  end
endmodule

// File: rtl/sbp_port_chk.sv
module sbp_port_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_clear,
  input logic tx_valid,
  input logic tx_ready,
  input logic rx_valid,
  input logic rx_ready,
  input logic stb_s,
  input logic ack_s,
  input logic intr,
  input logic ie_in,
  input logic ie_out
);
  assert_full_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !cfg_clear) |=> !tx_ready);

  assert_fill_needs_offer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_ready) |-> $past(tx_valid));

  assert_hold_while_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && ack_s && !cfg_clear) |=> !tx_ready);

  assert_load_needs_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> !$past(stb_s));

  assert_drain_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_valid) |-> ($past(rx_ready) || $past(cfg_clear)));

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    intr |-> $past((rx_valid && ie_in) || (tx_ready && ie_out)));

  assert_clear_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_clear) |-> (!rx_valid && tx_ready && !intr && !ie_in && !ie_out));
endmodule

bind sbp_port sbp_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_clear(cfg_clear), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .stb_s(stb_s), .ack_s(ack_s), .intr(intr), .ie_in(ie_in), .ie_out(ie_out)
);

// File: tb/tb_sbp_port.sv
module tb_sbp_port;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_clear = 1'b0;
  logic          tx_valid = 1'b0;
  logic          tx_ready;
  logic [DW-1:0] tx_data = '0;
  logic          rx_valid;
  logic          rx_ready = 1'b0;
  logic [DW-1:0] rx_data;
  logic          bsr_valid = 1'b0;
  logic [2:0]    bsr_index = '0;
  logic          bsr_value = 1'b0;
  logic          stb_n = 1'b1;
  logic          ack_n = 1'b1;
  logic          obf_n, ibf, intr, pad_oe;
  logic [DW-1:0] pad_in = '0;
  logic [DW-1:0] pad_out;
  logic [7:0]    status;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [DW-1:0] rx_q[$];
  logic [DW-1:0] tx_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sbp_port dut (
    .clk(clk), .rst_n(rst_n), .cfg_clear(cfg_clear), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .bsr_valid(bsr_valid),
    .bsr_index(bsr_index), .bsr_value(bsr_value), .stb_n(stb_n),
    .ack_n(ack_n), .obf_n(obf_n), .ibf(ibf), .intr(intr), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .status(status)
  );

  task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor for the receive channel
  always begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (rst_n && rx_valid && rx_ready) begin
      if (rx_q.size() == 0) check_eq("R4 unexpected receive transfer", 1, 0);
      else check_eq("R3 received byte", rx_data, rx_q.pop_front());
    end
  end

  task automatic strobe_byte(logic [DW-1:0] b);
    @(negedge clk);
    if (rx_q.size() > 0) rx_q.delete();   // unread byte gets replaced
    rx_q.push_back(b);
    pad_in = b;
    stb_n = 1'b0;
    repeat (4) @(negedge clk);
    stb_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_byte();
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic write_byte(logic [DW-1:0] b, int hold);
    @(negedge clk);
    tx_data = b;
    tx_valid = 1'b1;
    #1;
    if (tx_ready) tx_q.push_back(b);
    repeat (hold) @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic ack_pulse();
    @(negedge clk);
    ack_n = 1'b0;
    #1;
    check_eq("R2 driver on during ack", pad_oe, 1);
    if (tx_q.size() > 0) check_eq("R6 byte on pads", pad_out, tx_q.pop_front());
    repeat (4) @(negedge clk);
    check_eq("R5 ack empties output", obf_n, 1);
    ack_n = 1'b1;
    #1;
    check_eq("R2 driver off after ack", pad_oe, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic bit_cmd(logic [2:0] idx, logic val);
    @(negedge clk);
    bsr_valid = 1'b1;
    bsr_index = idx;
    bsr_value = val;
    @(negedge clk);
    bsr_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_eq("R1 status in reset", status, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 tx_ready", tx_ready, 1);
    check_eq("R1 obf_n", obf_n, 1);
    check_eq("R1 ibf", ibf, 0);
    check_eq("R1 rx_valid", rx_valid, 0);
    check_eq("R1 intr", intr, 0);
    check_eq("R1 status", status, 8'h00);
    check_eq("R1 pad_oe", pad_oe, 0);

    write_byte(8'hA5, 1);
    check_eq("R5 obf_n low after write", obf_n, 0);
    check_eq("R5 tx_ready low after write", tx_ready, 0);
    write_byte(8'h3C, 2);
    check_eq("R6 still back-pressured", tx_ready, 0);
    ack_pulse();
    check_eq("R5 tx_ready back after ack", tx_ready, 1);

    strobe_byte(8'h5A);
    check_eq("R3 ibf after strobe", ibf, 1);
    check_eq("R3 rx_valid after strobe", rx_valid, 1);
    read_byte();
    check_eq("R4 ibf cleared by read", ibf, 0);

    strobe_byte(8'h11);
    strobe_byte(8'h22);
    read_byte();
    check_eq("R3 overwrite leaves nothing", rx_q.size(), 0);

    bit_cmd(3'd4, 1'b1);
    check_eq("R7 input enable set", status, 8'h10);
    check_eq("R8 no irq while empty", intr, 0);
    bit_cmd(3'd2, 1'b1);
    bit_cmd(3'd5, 1'b1);
    check_eq("R7 other index ignored", status, 8'h10);

    strobe_byte(8'h77);
    check_eq("R8 input irq", intr, 1);
    check_eq("R11 status input side", status, 8'h38);
    read_byte();
    check_eq("R8 irq drops on read", intr, 0);

    bit_cmd(3'd6, 1'b1);
    check_eq("R9 output irq when empty", intr, 1);
    check_eq("R11 status enables and irq", status, 8'h58);
    write_byte(8'hC3, 1);
    check_eq("R9 irq drops on write", intr, 0);
    check_eq("R11 status while full", status, 8'hD0);
    ack_pulse();
    check_eq("R9 irq after ack release", intr, 1);
    bit_cmd(3'd6, 1'b0);
    check_eq("R7 output enable cleared", intr, 0);

    bit_cmd(3'd6, 1'b1);
    write_byte(8'hE1, 1);
    strobe_byte(8'h99);
    @(negedge clk);
    cfg_clear = 1'b1;
    @(negedge clk);
    cfg_clear = 1'b0;
    check_eq("R10 status cleared", status, 8'h00);
    check_eq("R10 rx empty", rx_valid, 0);
    check_eq("R10 tx ready", tx_ready, 1);
    check_eq("R10 intr low", intr, 0);
    rx_q.delete();
    tx_q.delete();
    repeat (3) @(negedge clk);
    check_eq("R10 intr stays low", intr, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule